// File: doc/BRIEF.md
# Synchronous Three-Domain Ratio Clock Generator

This block runs from one master clock and issues three clock-enable pulse trains for a processor domain, a high-speed interconnect domain and a peripheral-bus domain. Each train divides the master rate by a power of two, and all three stay phase-locked to one shared free-running counter. Software writes a single word that holds the three ratio codes and a source-select bit. A word with an illegal combination of ratios is refused, the error flag is raised and nothing changes. A legal word is held as pending and takes effect only when the shared counter wraps, so every pulse train changes at a common aligned boundary.

The same word also asks for the master source: the internal oscillator, which is selected after reset, or the PLL output. The block never drives both source selects at once. It first drops the current select. It then counts rising edges of the requested source, after synchronizing them into the master domain, and raises the new select only after the required number of edges.

Top module: `ratio_clkgen`

## Requirements
- R1: After reset the active codes are processor 00, interconnect 00 and peripheral 01. The error flag is 0, the oscillator select is 1, the PLL select is 0 and all enables are 0.
- R2: A domain with code c (00=÷1, 01=÷2, 10=÷4, 11=÷8) pulses its enable for one cycle whenever the low c bits of a shared 3-bit counter are zero. The counter starts at 0 after reset and the enable is registered one cycle after the counter value. Over 64 cycles, code c therefore gives 64/2^c pulses.
- R3: The write word carries the processor code in bits [1:0], the interconnect code in [3:2], the peripheral code in [5:4] and the source request in bit 6 (1 = PLL). An accepted word does not change the active codes in the cycle after the write.
- R4: A write whose peripheral code is 00 is refused. The error flag reads 1 from the cycle after the write, and the active codes are unchanged.
- R5: A write in which the processor code exceeds the interconnect code, or the interconnect code exceeds the peripheral code, is refused in the same way.
- R6: An accepted write clears the error flag in the cycle after the write.
- R7: Pending codes become active on the edge where the counter wraps from 7 to 0. A later accepted write before that wrap replaces the pending codes.
- R8: On a change of source request, the active select drops one cycle after the request register changes. Both selects stay low until two synchronized rising edges of the requested source, each passed through two synchronizer stages, have been seen. The requested select then rises. The two selects are never high together.
- R9: A refused write leaves the source request unchanged, so the selected source stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 7 | Control word: three ratio codes and source request |
| osc_clk_i | input | 1 | Internal oscillator clock, sampled as data |
| pll_clk_i | input | 1 | PLL output clock, sampled as data |
| ce_cpu_o | output | 1 | Processor-domain enable pulse |
| ce_axi_o | output | 1 | Interconnect-domain enable pulse |
| ce_ahb_o | output | 1 | Peripheral-bus-domain enable pulse |
| cur_cpu_o | output | 2 | Active processor ratio code |
| cur_axi_o | output | 2 | Active interconnect ratio code |
| cur_ahb_o | output | 2 | Active peripheral ratio code |
| err_o | output | 1 | Last write was refused |
| sel_osc_o | output | 1 | Oscillator selected |
| sel_pll_o | output | 1 | PLL selected (active-source status) |

## Verification
The bench uses the default parameters: 2-bit codes, two synchronizer stages and two edges before a source switch. With these values the counter wraps every 8 cycles, so all four codes in each domain can be reached, and short runs already hit writes that land just before a wrap and pending words that get replaced. The source inputs toggle slowly, at three and five master cycles per half period, so the deselect gap and the edge counting show up as distinct cycles that the reference model predicts exactly.

// File: rtl/ratio_clkgen_pkg.sv
package ratio_clkgen_pkg;

  typedef enum logic [1:0] {
    SRC_OSC = 2'd0,
    SRC_PLL = 2'd1,
    SRC_OFF = 2'd2
  } src_state_t;

  localparam int NUM_DOM = 3;
  localparam int DOM_CPU = 0;
  localparam int DOM_AXI = 1;
  localparam int DOM_AHB = 2;

endpackage

// File: rtl/ratio_regs.sv
module ratio_regs #(
  parameter int              CODE_W  = 2,
  parameter logic [CODE_W-1:0] RST_CPU = '0,
  parameter logic [CODE_W-1:0] RST_AXI = '0,
  parameter logic [CODE_W-1:0] RST_AHB = 1
) (
  input  logic                                                  clk,
  input  logic                                                  rst,
  input  logic                                                  wr_en_i,
  input  logic [ratio_clkgen_pkg::NUM_DOM*CODE_W:0]             wr_data_i,
  input  logic                                                  wrap_i,
  output logic [ratio_clkgen_pkg::NUM_DOM-1:0][CODE_W-1:0]      act_o,
  output logic                                                  err_o,
  output logic                                                  src_req_o
);
  import ratio_clkgen_pkg::*;

  localparam int SRC_BIT = NUM_DOM * CODE_W;
  localparam logic [NUM_DOM-1:0][CODE_W-1:0] RST_V = {RST_AHB, RST_AXI, RST_CPU};

  logic [NUM_DOM-1:0][CODE_W-1:0] w_code;
  logic [NUM_DOM-1:0][CODE_W-1:0] pend_val_q;
  logic                           pend_q;
  logic                           w_legal;

  genvar d;
  generate
    for (d = 0; d < NUM_DOM; d++) begin : g_field
      assign w_code[d] = wr_data_i[d*CODE_W +: CODE_W];
    end
  endgenerate

  // slower domain must never get a smaller code than a faster one
  assign w_legal = (w_code[DOM_AHB] != '0) &&
                   (w_code[DOM_CPU] <= w_code[DOM_AXI]) &&
                   (w_code[DOM_AXI] <= w_code[DOM_AHB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o      <= RST_V;
      pend_val_q <= RST_V;
      pend_q     <= 1'b0;
      err_o      <= 1'b0;
      src_req_o  <= 1'b0;
    end else begin
      if (wrap_i && pend_q) begin
        act_o <= pend_val_q;
      end
      if (wr_en_i && w_legal) begin
        pend_val_q <= w_code;
        pend_q     <= 1'b1;
        err_o      <= 1'b0;
        src_req_o  <= wr_data_i[SRC_BIT];
      end else begin
        if (wr_en_i) begin
          err_o <= 1'b1;
        end
        if (wrap_i) begin
          pend_q <= 1'b0;
        end
      end
    end
  end

  p_ahb_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    act_o[DOM_AHB] != '0);

  p_order_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (act_o[DOM_CPU] <= act_o[DOM_AXI]) && (act_o[DOM_AXI] <= act_o[DOM_AHB]));

  p_apply_on_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_o) |-> $past(wrap_i));

  p_refused_keeps_src_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !w_legal) |=> $stable(src_req_o));

endmodule

// File: rtl/ratio_ce_gen.sv
module ratio_ce_gen #(
  parameter int CODE_W  = 2,
  parameter int NUM_DOM = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_DOM-1:0][CODE_W-1:0]   code_i,
  output logic                             wrap_o,
  output logic [NUM_DOM-1:0]               ce_o
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = &cnt_q;

  genvar d;
  generate
    for (d = 0; d < NUM_DOM; d++) begin : g_dom
      logic [CNT_W-1:0] mask;
      logic             ce_q;
      assign mask = CNT_W'((32'd1 << code_i[d]) - 32'd1);
      always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b0;
        else     ce_q <= ((cnt_q & mask) == '0);
      end
      assign ce_o[d] = ce_q;
    end
  endgenerate

  p_all_fire_after_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> ##1 (&ce_o));

endmodule

// File: rtl/src_switch.sv
module src_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int EDGES_REQ   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_pll_i,
  input  logic osc_clk_i,
  input  logic pll_clk_i,
  output logic sel_osc_o,
  output logic sel_pll_o
);
  import ratio_clkgen_pkg::*;

  localparam int EW = $clog2(EDGES_REQ + 1);

  logic [1:0] raw_in;
  logic [1:0] rise;
  src_state_t state_q;
  logic       tgt_q;
  logic [EW-1:0] edges_q;

  assign raw_in = {pll_clk_i, osc_clk_i};

  genvar s;
  generate
    for (s = 0; s < 2; s++) begin : g_sync
      logic [SYNC_STAGES:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], raw_in[s]};
      end
      assign rise[s] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_OSC;
      tgt_q   <= 1'b0;
      edges_q <= '0;
    end else begin
      case (state_q)
        SRC_OSC: if (req_pll_i) begin
          state_q <= SRC_OFF;
          tgt_q   <= 1'b1;
          edges_q <= '0;
        end
        SRC_PLL: if (!req_pll_i) begin
          state_q <= SRC_OFF;
          tgt_q   <= 1'b0;
          edges_q <= '0;
        end
        SRC_OFF: if (rise[tgt_q]) begin
          if (edges_q == EW'(EDGES_REQ - 1)) state_q <= tgt_q ? SRC_PLL : SRC_OSC;
          else                               edges_q <= edges_q + 1'b1;
        end
        default: state_q <= SRC_OSC;
      endcase
    end
  end

  assign sel_osc_o = (state_q == SRC_OSC);
  assign sel_pll_o = (state_q == SRC_PLL);

  p_never_both_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_osc_o, sel_pll_o}));

  p_deselect_first_r8: assert property (@(posedge clk) disable iff (rst)
    (sel_osc_o && req_pll_i) |=> (!sel_osc_o && !sel_pll_o));

  p_gap_before_pll_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_pll_o) |-> $past(!sel_osc_o && !sel_pll_o));

endmodule

// File: rtl/ratio_clkgen.sv
module ratio_clkgen #(
  parameter int                CODE_W      = 2,
  parameter int                SYNC_STAGES = 2,
  parameter int                EDGES_REQ   = 2,
  parameter logic [CODE_W-1:0] RST_CPU     = '0,
  parameter logic [CODE_W-1:0] RST_AXI     = '0,
  parameter logic [CODE_W-1:0] RST_AHB     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [3*CODE_W:0] wr_data_i,
  input  logic              osc_clk_i,
  input  logic              pll_clk_i,
  output logic              ce_cpu_o,
  output logic              ce_axi_o,
  output logic              ce_ahb_o,
  output logic [CODE_W-1:0] cur_cpu_o,
  output logic [CODE_W-1:0] cur_axi_o,
  output logic [CODE_W-1:0] cur_ahb_o,
  output logic              err_o,
  output logic              sel_osc_o,
  output logic              sel_pll_o
);
  import ratio_clkgen_pkg::*;

  logic [NUM_DOM-1:0][CODE_W-1:0] act;
  logic [NUM_DOM-1:0]             ce;
  logic                           wrap;
  logic                           src_req;

  ratio_regs #(
    .CODE_W (CODE_W),
    .RST_CPU(RST_CPU),
    .RST_AXI(RST_AXI),
    .RST_AHB(RST_AHB)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wrap_i   (wrap),
    .act_o    (act),
    .err_o    (err_o),
    .src_req_o(src_req)
  );

  ratio_ce_gen #(
    .CODE_W (CODE_W),
    .NUM_DOM(NUM_DOM)
  ) i_ce (
    .clk   (clk),
    .rst   (rst),
    .code_i(act),
    .wrap_o(wrap),
    .ce_o  (ce)
  );

  src_switch #(
    .SYNC_STAGES(SYNC_STAGES),
    .EDGES_REQ  (EDGES_REQ)
  ) i_src (
    .clk      (clk),
    .rst      (rst),
    .req_pll_i(src_req),
    .osc_clk_i(osc_clk_i),
    .pll_clk_i(pll_clk_i),
    .sel_osc_o(sel_osc_o),
    .sel_pll_o(sel_pll_o)
  );

  assign ce_cpu_o  = ce[DOM_CPU];
  assign ce_axi_o  = ce[DOM_AXI];
  assign ce_ahb_o  = ce[DOM_AHB];
  assign cur_cpu_o = act[DOM_CPU];
  assign cur_axi_o = act[DOM_AXI];
  assign cur_ahb_o = act[DOM_AHB];

  // a slower enable may only fire together with every faster one
  p_ce_nested_r2: assert property (@(posedge clk) disable iff (rst)
    (ce_ahb_o |-> ce_axi_o) and (ce_axi_o |-> ce_cpu_o));

endmodule

// File: tb/test_ratio_clkgen.sv
module test_ratio_clkgen;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [6:0] wr_data;
  logic       osc_in;
  logic       pll_in;
  logic       ce_cpu_o, ce_axi_o, ce_ahb_o;
  logic [1:0] cur_cpu_o, cur_axi_o, cur_ahb_o;
  logic       err_o, sel_osc_o, sel_pll_o;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;

  // reference model state
  int mcnt;
  int mact[3];
  int mpv[3];
  int mce[3];
  int mpend, merr, msrc;
  int mstate;              // 0 osc, 1 pll, 2 none selected
  int mtgt, medges;
  int mo[3];
  int mp[3];

  ratio_clkgen i_ratio_clkgen (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .osc_clk_i(osc_in), .pll_clk_i(pll_in),
    .ce_cpu_o(ce_cpu_o), .ce_axi_o(ce_axi_o), .ce_ahb_o(ce_ahb_o),
    .cur_cpu_o(cur_cpu_o), .cur_axi_o(cur_axi_o), .cur_ahb_o(cur_ahb_o),
    .err_o(err_o), .sel_osc_o(sel_osc_o), .sel_pll_o(sel_pll_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      started = 1;
      mcnt = 0; mact = '{0, 0, 1}; mpv = '{0, 0, 1}; mce = '{0, 0, 0};
      mpend = 0; merr = 0; msrc = 0; mstate = 0; mtgt = 0; medges = 0;
      mo = '{0, 0, 0}; mp = '{0, 0, 0};
    end else begin
      int ro, rp, c, a, h;
      bit ok;
      for (int d = 0; d < 3; d++) mce[d] = ((mcnt % (1 << mact[d])) == 0);
      ro = mo[1] && !mo[2];
      rp = mp[1] && !mp[2];
      if (mstate == 0 && msrc == 1) begin mstate = 2; mtgt = 1; medges = 0; end
      else if (mstate == 1 && msrc == 0) begin mstate = 2; mtgt = 0; medges = 0; end
      else if (mstate == 2 && ((mtgt == 1) ? rp : ro)) begin
        if (medges == 1) mstate = mtgt;
        else medges++;
      end
      mo[2] = mo[1]; mo[1] = mo[0]; mo[0] = osc_in;
      mp[2] = mp[1]; mp[1] = mp[0]; mp[0] = pll_in;
      if (mcnt == 7 && mpend) begin mact = mpv; end
      if (mcnt == 7) mpend = 0;
      if (wr_en) begin
        c = wr_data[1:0]; a = wr_data[3:2]; h = wr_data[5:4];
        ok = (h != 0) && (c <= a) && (a <= h);
        if (ok) begin
          mpv = '{c, a, h}; mpend = 1; merr = 0; msrc = wr_data[6];
        end else merr = 1;
      end
      mcnt = (mcnt + 1) % 8;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R2 enables vs model", {ce_cpu_o, ce_axi_o, ce_ahb_o}, {mce[0][0], mce[1][0], mce[2][0]});
      chk("R7 active codes vs model", {cur_cpu_o, cur_axi_o, cur_ahb_o},
          {mact[0][1:0], mact[1][1:0], mact[2][1:0]});
      chk("R4 error flag vs model", err_o, merr);
      chk("R8 selects vs model", {sel_osc_o, sel_pll_o}, {mstate == 0, mstate == 1});
    end
  end

  task automatic wr(input logic [6:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic count_ce(input int n, output int c0, output int c1, output int c2);
    c0 = 0; c1 = 0; c2 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c0 += ce_cpu_o; c1 += ce_axi_o; c2 += ce_ahb_o;
    end
  endtask

  task automatic settle();
    repeat (9) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // slow source clocks, driven just after each master edge
  initial begin
    int ko, kp;
    osc_in = 1'b0; pll_in = 1'b0; ko = 0; kp = 0;
    forever begin
      @(posedge clk); #1;
      ko++; kp++;
      if (ko == 3) begin osc_in = ~osc_in; ko = 0; end
      if (kp == 5) begin pll_in = ~pll_in; kp = 0; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, c1, c2;
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 cpu code", cur_cpu_o, 0);
    chk("R1 axi code", cur_axi_o, 0);
    chk("R1 ahb code", cur_ahb_o, 1);
    chk("R1 error", err_o, 0);
    chk("R1 osc select", sel_osc_o, 1);
    chk("R1 pll select", sel_pll_o, 0);
    chk("R1 enables", {ce_cpu_o, ce_axi_o, ce_ahb_o}, 0);

    count_ce(64, c0, c1, c2);
    chk("R2 default cpu pulses", c0, 64);
    chk("R2 default axi pulses", c1, 64);
    chk("R2 default ahb pulses", c2, 32);

    wr(7'b0_10_01_00);
    @(negedge clk);
    chk("R3 axi not yet active", cur_axi_o, 0);
    chk("R3 ahb not yet active", cur_ahb_o, 1);
    settle();
    chk("R7 axi applied", cur_axi_o, 1);
    chk("R7 ahb applied", cur_ahb_o, 2);
    count_ce(64, c0, c1, c2);
    chk("R2 cpu /1 pulses", c0, 64);
    chk("R2 axi /2 pulses", c1, 32);
    chk("R2 ahb /4 pulses", c2, 16);

    wr(7'b0_00_00_00);
    @(negedge clk);
    chk("R4 zero ahb sets error", err_o, 1);
    settle();
    chk("R4 codes unchanged", {cur_cpu_o, cur_axi_o, cur_ahb_o}, 6'b00_01_10);

    wr(7'b0_11_01_10);
    @(negedge clk);
    chk("R5 cpu slower than axi refused", err_o, 1);
    wr(7'b0_10_11_00);
    @(negedge clk);
    chk("R5 axi slower than ahb refused", err_o, 1);
    settle();
    chk("R5 codes unchanged", {cur_cpu_o, cur_axi_o, cur_ahb_o}, 6'b00_01_10);

    wr(7'b0_11_01_01);
    @(negedge clk);
    chk("R6 accepted write clears error", err_o, 0);
    settle();
    chk("R3 fields land in place", {cur_cpu_o, cur_axi_o, cur_ahb_o}, 6'b01_01_11);

    while (mcnt != 1) @(negedge clk);
    wr(7'b0_11_11_11);
    wr(7'b0_10_10_10);
    settle();
    chk("R7 later write replaces pending", {cur_cpu_o, cur_axi_o, cur_ahb_o}, 6'b10_10_10);
    count_ce(64, c0, c1, c2);
    chk("R2 all /4 cpu", c0, 16);
    chk("R2 all /4 ahb", c2, 16);

    wr(7'b0_11_11_11);
    settle();
    count_ce(64, c0, c1, c2);
    chk("R2 all /8 axi", c1, 8);
    chk("R2 all /8 ahb", c2, 8);

    wr(7'b1_11_11_11);
    @(negedge clk);
    chk("R8 osc held one more cycle", sel_osc_o, 1);
    @(negedge clk);
    chk("R8 gap with nothing selected", {sel_osc_o, sel_pll_o}, 2'b00);
    for (int i = 0; i < 200 && !sel_pll_o; i++) @(negedge clk);
    chk("R8 pll selected", sel_pll_o, 1);
    chk("R8 osc released", sel_osc_o, 0);

    wr(7'b0_00_11_11);
    @(negedge clk);
    chk("R9 refused write flags error", err_o, 1);
    repeat (20) @(negedge clk);
    chk("R9 pll stays selected", sel_pll_o, 1);
    chk("R9 codes unchanged", {cur_cpu_o, cur_axi_o, cur_ahb_o}, 6'b11_11_11);

    wr(7'b0_01_00_00);
    for (int i = 0; i < 200 && !sel_osc_o; i++) @(negedge clk);
    chk("R8 back on oscillator", {sel_osc_o, sel_pll_o}, 2'b10);
    repeat (10) @(negedge clk);

    finish_run();
  end

endmodule